// File: doc/BRIEF.md
# Command-Driven SPI Controller Host Register Block

This block is the memory-mapped front end that a processor uses to drive a command-driven SPI controller. It decodes single-cycle 32-bit word reads and writes on a simple strobe bus. Behind the decode sit an identification word, a hold-in-reset control for the execution engine, interrupt enable, pending and masked-source registers, the identifier of the most recent sync command, and occupancy counters for three internal FIFOs.

Software fills a command FIFO with 16-bit instructions and a transmit FIFO with bytes. The execution engine drains both through its own pop strobes and pushes received bytes into a receive FIFO. Software empties that FIFO through a consuming window, or looks at its head through a non-consuming window. Watermark conditions on the three FIFOs, plus a pulse that reports each executed sync command, set pending bits. Their enabled OR drives one registered, level-sensitive interrupt line.

Top module: `spix_host_regs`

## Requirements
- R1: A read of byte offset 0x00 returns the identification word: bits 23:16 hold major version 1, bits 15:8 the minor version parameter (default 1) and bits 7:0 the patch parameter (default 0), with bits 31:24 zero. The default word is 0x00010100.
- R2: Offset 0x40 is the engine hold register. It reads back bit 0 and resets to 1. `eng_rst_o` shows bit 0 of the last value written there, starting in the cycle after the write.
- R3: Offset 0x80 is a 4-bit interrupt enable register. It resets to 0 and reads back the low four bits written to it.
- R4: Offset 0x84 reads the pending bits. Bit 0 sets while the command FIFO holds no more than CMD_LOW_MARK entries (default 4). Bit 1 sets while the transmit FIFO holds no more than TX_LOW_MARK entries (default 4). Bit 2 sets while the receive FIFO holds at least RX_HIGH_MARK entries (default 12). Bit 3 sets on each cycle in which `sync_evt_i` is high. Each bit is set at the clock edge that ends the cycle in which its condition is seen, and stays set until it is cleared.
- R5: Writing to 0x84 clears every pending bit whose write-data bit is 1 and leaves the others unchanged, so 0xFF clears all of them. A watermark bit whose condition still holds reads 1 again straight after the clear.
- R6: A read of 0x88 returns the pending bits ANDed with the enable bits.
- R7: `irq_o` is registered. It is high in a cycle exactly when the pending bits ANDed with the enable bits were non-zero in the previous cycle.
- R8: On each cycle with `sync_evt_i` high, the 8-bit register at 0xC0 takes `sync_id_i`. This happens at the same edge that sets pending bit 3.
- R9: 0xD0 returns the free entries of the command FIFO and 0xD4 the free entries of the transmit FIFO. 0xD8 returns the number of entries in the receive FIFO. All three FIFOs default to 16 entries.
- R10: A write to 0xE0 pushes `bus_wdata[15:0]` into the command FIFO, and a write to 0xE4 pushes `bus_wdata[7:0]` into the transmit FIFO. Each FIFO presents its oldest entry on its data output and removes it on a pop strobe from the engine, in first-in first-out order.
- R11: A read of 0xE8 returns the oldest received byte and removes it. A read of 0xEC returns the same byte without removing it. All read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R12: A push into a full FIFO and a pop from an empty FIFO are ignored and leave the contents and counters unchanged. Reads of 0xE8 or 0xEC while the receive FIFO is empty return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the access; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Level interrupt request |
| eng_rst_o | output | 1 | Holds the execution engine in reset while high |
| cmd_pop_i | input | 1 | Engine removes the oldest command |
| cmd_data_o | output | 16 | Oldest command |
| cmd_empty_o | output | 1 | Command FIFO is empty |
| tx_pop_i | input | 1 | Engine removes the oldest transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit FIFO is empty |
| rx_push_i | input | 1 | Engine stores a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive FIFO is full |
| sync_evt_i | input | 1 | One-cycle pulse for an executed sync command |
| sync_id_i | input | 8 | Identifier carried by that sync command |

## Verification
The assertions take one bus access per cycle as given, with read and write strobes never high together. They also assume `sync_id_i` is meaningful only while `sync_evt_i` is high. The overflow property further assumes the engine does not pop the command FIFO in the cycle under test. The bench drives all accesses through tasks that raise exactly one strobe for one cycle. Its random phase picks a single action per cycle: a command push or pop, or a receive push or pop. Sync pulses appear only in directed steps, where no access overlaps them.

// File: rtl/spix_pkg.sv
`timescale 1ns/1ps
package spix_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam int IRQ_N  = 4;

  localparam logic [BUS_AW-1:0] OFS_IDENT    = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_HOLD     = 8'h40;
  localparam logic [BUS_AW-1:0] OFS_IEN      = 8'h80;
  localparam logic [BUS_AW-1:0] OFS_IPEND    = 8'h84;
  localparam logic [BUS_AW-1:0] OFS_ISRC     = 8'h88;
  localparam logic [BUS_AW-1:0] OFS_SYNC     = 8'hC0;
  localparam logic [BUS_AW-1:0] OFS_CMD_ROOM = 8'hD0;
  localparam logic [BUS_AW-1:0] OFS_TX_ROOM  = 8'hD4;
  localparam logic [BUS_AW-1:0] OFS_RX_LVL   = 8'hD8;
  localparam logic [BUS_AW-1:0] OFS_CMD_PUSH = 8'hE0;
  localparam logic [BUS_AW-1:0] OFS_TX_PUSH  = 8'hE4;
  localparam logic [BUS_AW-1:0] OFS_RX_POP   = 8'hE8;
  localparam logic [BUS_AW-1:0] OFS_RX_PEEK  = 8'hEC;

  // interrupt bit positions, decoded by software
  localparam int IRQ_CMD_LO = 0;
  localparam int IRQ_TX_LO  = 1;
  localparam int IRQ_RX_HI  = 2;
  localparam int IRQ_SYNC   = 3;

  localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/spix_fifo.sv
`timescale 1ns/1ps
module spix_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign level = cnt;
endmodule

// File: rtl/spix_irq.sv
`timescale 1ns/1ps
module spix_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pend_q,
  output logic         irq_o
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      // a live condition overrides a clear in the same cycle
      pend_q <= (pend_q & ~clr_eff) | cond;
      irq_o  <= |(pend_q & en_q);
    end
  end
endmodule

// File: rtl/spix_host_regs.sv
`timescale 1ns/1ps
module spix_host_regs
  import spix_pkg::*;
#(
  parameter int         CMD_DEPTH    = 16,
  parameter int         TX_DEPTH     = 16,
  parameter int         RX_DEPTH     = 16,
  parameter int         CMD_LOW_MARK = 4,
  parameter int         TX_LOW_MARK  = 4,
  parameter int         RX_HIGH_MARK = 12,
  parameter int         CMD_W        = 16,
  parameter int         DATA_W       = 8,
  parameter int         ID_W         = 8,
  parameter logic [7:0] VER_MINOR    = 8'd1,
  parameter logic [7:0] VER_PATCH    = 8'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_o,
  output logic              eng_rst_o,
  input  logic              cmd_pop_i,
  output logic [CMD_W-1:0]  cmd_data_o,
  output logic              cmd_empty_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_full_o,
  input  logic              sync_evt_i,
  input  logic [ID_W-1:0]   sync_id_i
);
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int TX_CW  = $clog2(TX_DEPTH + 1);
  localparam int RX_CW  = $clog2(RX_DEPTH + 1);
  localparam int WA     = BUS_AW - 2;

  logic [WA-1:0]     word;
  logic              wr_cmd, wr_tx, wr_ien, wr_ipend, wr_hold, rd_pop;
  logic [CMD_CW-1:0] cmd_lvl;
  logic [TX_CW-1:0]  tx_lvl;
  logic [RX_CW-1:0]  rx_lvl;
  logic              cmd_full, tx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic [IRQ_N-1:0]  cond, en_q, pend_q;
  logic [ID_W-1:0]   sync_q;
  logic              hold_q;
  logic [BUS_DW-1:0] rd_mux;
  logic              unused_bits;

  assign word     = bus_addr[BUS_AW-1:2];
  assign wr_cmd   = bus_wr && (word == OFS_CMD_PUSH[BUS_AW-1:2]);
  assign wr_tx    = bus_wr && (word == OFS_TX_PUSH[BUS_AW-1:2]);
  assign wr_ien   = bus_wr && (word == OFS_IEN[BUS_AW-1:2]);
  assign wr_ipend = bus_wr && (word == OFS_IPEND[BUS_AW-1:2]);
  assign wr_hold  = bus_wr && (word == OFS_HOLD[BUS_AW-1:2]);
  assign rd_pop   = bus_rd && (word == OFS_RX_POP[BUS_AW-1:2]);

  spix_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH), .CW(CMD_CW)) u_cmd_fifo (
    .clk(clk), .rst(rst), .push(wr_cmd), .din(bus_wdata[CMD_W-1:0]),
    .pop(cmd_pop_i), .dout(cmd_data_o), .empty(cmd_empty_o),
    .full(cmd_full), .level(cmd_lvl)
  );

  spix_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH), .CW(TX_CW)) u_tx_fifo (
    .clk(clk), .rst(rst), .push(wr_tx), .din(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop_i), .dout(tx_data_o), .empty(tx_empty_o),
    .full(tx_full), .level(tx_lvl)
  );

  spix_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH), .CW(RX_CW)) u_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push_i), .din(rx_data_i),
    .pop(rd_pop), .dout(rx_head), .empty(rx_empty),
    .full(rx_full_o), .level(rx_lvl)
  );

  // watermark levels and the sync pulse feed the pending register
  always_comb begin
    cond             = '0;
    cond[IRQ_CMD_LO] = int'(cmd_lvl) <= CMD_LOW_MARK;
    cond[IRQ_TX_LO]  = int'(tx_lvl) <= TX_LOW_MARK;
    cond[IRQ_RX_HI]  = int'(rx_lvl) >= RX_HIGH_MARK;
    cond[IRQ_SYNC]   = sync_evt_i;
  end

  spix_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .cond(cond),
    .en_wr(wr_ien), .en_wdata(bus_wdata[IRQ_N-1:0]),
    .clr_wr(wr_ipend), .clr_mask(bus_wdata[IRQ_N-1:0]),
    .en_q(en_q), .pend_q(pend_q), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hold_q <= 1'b1;
    end else begin
      if (sync_evt_i) sync_q <= sync_id_i;
      if (wr_hold)    hold_q <= bus_wdata[0];
    end
  end

  assign eng_rst_o = hold_q;

  always_comb begin
    rd_mux = '0;
    case (word)
      OFS_IDENT[BUS_AW-1:2]:    rd_mux = BUS_DW'({VER_MAJOR, VER_MINOR, VER_PATCH});
      OFS_HOLD[BUS_AW-1:2]:     rd_mux = BUS_DW'(hold_q);
      OFS_IEN[BUS_AW-1:2]:      rd_mux = BUS_DW'(en_q);
      OFS_IPEND[BUS_AW-1:2]:    rd_mux = BUS_DW'(pend_q);
      OFS_ISRC[BUS_AW-1:2]:     rd_mux = BUS_DW'(pend_q & en_q);
      OFS_SYNC[BUS_AW-1:2]:     rd_mux = BUS_DW'(sync_q);
      OFS_CMD_ROOM[BUS_AW-1:2]: rd_mux = BUS_DW'(CMD_DEPTH) - BUS_DW'(cmd_lvl);
      OFS_TX_ROOM[BUS_AW-1:2]:  rd_mux = BUS_DW'(TX_DEPTH) - BUS_DW'(tx_lvl);
      OFS_RX_LVL[BUS_AW-1:2]:   rd_mux = BUS_DW'(rx_lvl);
      OFS_RX_POP[BUS_AW-1:2],
      OFS_RX_PEEK[BUS_AW-1:2]:  rd_mux = rx_empty ? '0 : BUS_DW'(rx_head);
      default:                  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign unused_bits = ^{bus_addr[1:0], bus_wdata, cmd_full, tx_full};
endmodule

// File: rtl/spix_host_regs_chk.sv
`timescale 1ns/1ps
module spix_host_regs_chk
  import spix_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int CMD_CW    = 5,
  parameter int RX_CW     = 5,
  parameter int ID_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BUS_AW-3:0] word,
  input logic [IRQ_N-1:0]  wdata_lo,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic              irq_o,
  input logic              eng_rst_o,
  input logic              cmd_pop_i,
  input logic              sync_evt_i,
  input logic [ID_W-1:0]   sync_id_i,
  input logic [IRQ_N-1:0]  en_q,
  input logic [IRQ_N-1:0]  pend_q,
  input logic [ID_W-1:0]   sync_q,
  input logic [CMD_CW-1:0] cmd_lvl,
  input logic [RX_CW-1:0]  rx_lvl
);
  // R2: hold output follows the written bit
  a_r2_hold_follows: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (word == OFS_HOLD[BUS_AW-1:2]) |=> eng_rst_o == $past(wdata_lo[0]));

  // R3: enable register takes the written bits
  a_r3_enable_write: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (word == OFS_IEN[BUS_AW-1:2]) |=> en_q == $past(wdata_lo));

  // R5: a clear of the sync bit without a new event empties it
  a_r5_sync_clear: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (word == OFS_IPEND[BUS_AW-1:2]) && wdata_lo[IRQ_SYNC] && !sync_evt_i
    |=> !pend_q[IRQ_SYNC]);

  // R7: no request when nothing was enabled
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0) |-> !irq_o);

  // R8: identifier and pending bit land on the same edge
  a_r8_sync_capture: assert property (@(posedge clk) disable iff (rst)
    sync_evt_i |=> pend_q[IRQ_SYNC] && (sync_q == $past(sync_id_i)));

  // R12: a full command FIFO does not grow
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cmd_lvl == CMD_CW'(CMD_DEPTH)) && !cmd_pop_i |=> cmd_lvl == $past(cmd_lvl));

  // R12: empty receive windows read zero
  a_r12_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl == '0) && bus_rd &&
    ((word == OFS_RX_POP[BUS_AW-1:2]) || (word == OFS_RX_PEEK[BUS_AW-1:2]))
    |=> bus_rdata == '0);

  // R9: level never exceeds capacity
  a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cmd_lvl) <= CMD_DEPTH);
endmodule

bind spix_host_regs spix_host_regs_chk #(
  .CMD_DEPTH(CMD_DEPTH), .CMD_CW(CMD_CW), .RX_CW(RX_CW), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .word(bus_addr[7:2]), .wdata_lo(bus_wdata[3:0]), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .eng_rst_o(eng_rst_o), .cmd_pop_i(cmd_pop_i),
  .sync_evt_i(sync_evt_i), .sync_id_i(sync_id_i), .en_q(en_q),
  .pend_q(pend_q), .sync_q(sync_q), .cmd_lvl(cmd_lvl), .rx_lvl(rx_lvl)
);

// File: tb/spix_host_regs_bench.sv
`timescale 1ns/1ps
module spix_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, eng_rst_o;
  logic        cmd_pop_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, sync_evt_i = 1'b0;
  logic [15:0] cmd_data_o;
  logic [7:0]  tx_data_o, rx_data_i = '0, sync_id_i = '0;
  logic        cmd_empty_o, tx_empty_o, rx_full_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spix_host_regs u_spix_host_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .eng_rst_o(eng_rst_o),
    .cmd_pop_i(cmd_pop_i), .cmd_data_o(cmd_data_o), .cmd_empty_o(cmd_empty_o),
    .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .tx_empty_o(tx_empty_o),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .rx_full_o(rx_full_o),
    .sync_evt_i(sync_evt_i), .sync_id_i(sync_id_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic cmd_pop();
    cmd_pop_i = 1'b1; @(negedge clk); cmd_pop_i = 1'b0;
  endtask

  task automatic tx_pop();
    tx_pop_i = 1'b1; @(negedge clk); tx_pop_i = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] v);
    rx_push_i = 1'b1; rx_data_i = v; @(negedge clk); rx_push_i = 1'b0;
  endtask

  task automatic sync_pulse(input logic [7:0] id);
    sync_evt_i = 1'b1; sync_id_i = id; @(negedge clk); sync_evt_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected watermark bits for given FIFO fill levels (R4 thresholds)
  function automatic logic [31:0] exp_wm(input int c, input int t, input int r);
    logic [31:0] v = '0;
    v[0] = (c <= 4);
    v[1] = (t <= 4);
    v[2] = (r >= 12);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] cq[$];
    logic [7:0]  rq[$];
    logic [31:0] d;
    void'($urandom(32'd7071));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("reset irq", {31'd0, irq_o}, 0);
    chk("R2 reset hold", {31'd0, eng_rst_o}, 1);
    chk("reset rdata", bus_rdata, 0);
    chk("reset empties", {29'd0, cmd_empty_o, tx_empty_o, rx_full_o}, 3'b110);

    rd_chk("R1 ident", 8'h00, 32'h0001_0100);
    rd_chk("R2 hold read", 8'h40, 1);
    wr(8'h40, 0);
    chk("R2 hold released", {31'd0, eng_rst_o}, 0);
    rd_chk("R2 hold readback", 8'h40, 0);

    rd_chk("R3 enable reset", 8'h80, 0);
    rd_chk("R4 empty fifos pend", 8'h84, 3);
    chk("R7 no enable no irq", {31'd0, irq_o}, 0);
    wr(8'h80, 32'hFFFF_FFFF);
    rd_chk("R3 enable readback", 8'h80, 32'hF);
    idle(2);
    chk("R7 irq raised", {31'd0, irq_o}, 1);
    rd_chk("R6 source all", 8'h88, 3);
    wr(8'h80, 8);
    idle(2);
    chk("R7 irq masked", {31'd0, irq_o}, 0);
    rd_chk("R6 source masked", 8'h88, 0);
    wr(8'h84, 3);
    rd_chk("R5 watermark reasserts", 8'h84, 3);

    sync_pulse(8'hA5);
    idle(1);
    chk("R7 irq on sync", {31'd0, irq_o}, 1);
    rd_chk("R8 sync id", 8'hC0, 32'hA5);
    rd_chk("R4 sync pending", 8'h84, 32'hB);
    wr(8'h84, 8);
    rd_chk("R5 sync cleared", 8'h84, 3);
    chk("R7 irq drops", {31'd0, irq_o}, 0);
    sync_pulse(8'h3C);
    rd_chk("R8 second id", 8'hC0, 32'h3C);
    wr(8'h84, 32'hFF);
    rd_chk("R5 clear all", 8'h84, 3);

    // command FIFO order and room
    for (int i = 0; i < 5; i++) wr(8'hE0, 32'hA000 + i);
    rd_chk("R9 cmd room", 8'hD0, 11);
    wr(8'h84, 1);
    rd_chk("R4 cmd above mark", 8'h84, 2);
    for (int i = 0; i < 5; i++) begin
      chk("R10 cmd order", {16'd0, cmd_data_o}, 32'hA000 + i);
      cmd_pop();
    end
    chk("R10 cmd drained", {31'd0, cmd_empty_o}, 1);

    for (int i = 0; i < 17; i++) wr(8'hE0, 32'h100 + i);
    rd_chk("R12 cmd full room", 8'hD0, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R12 cmd overflow dropped", {16'd0, cmd_data_o}, 32'h100 + i);
      cmd_pop();
    end
    chk("R12 cmd empty", {31'd0, cmd_empty_o}, 1);
    cmd_pop();
    wr(8'hE0, 32'hBEEF);
    rd_chk("R12 pop empty ignored", 8'hD0, 15);
    chk("R10 cmd head", {16'd0, cmd_data_o}, 32'hBEEF);
    cmd_pop();

    // transmit FIFO
    wr(8'hE4, 32'h5A); wr(8'hE4, 32'hC3); wr(8'hE4, 32'h17E);
    rd_chk("R9 tx room", 8'hD4, 13);
    chk("R10 tx b0", {24'd0, tx_data_o}, 32'h5A); tx_pop();
    chk("R10 tx b1", {24'd0, tx_data_o}, 32'hC3); tx_pop();
    chk("R10 tx b2", {24'd0, tx_data_o}, 32'h7E); tx_pop();
    chk("R10 tx empty", {31'd0, tx_empty_o}, 1);

    // receive windows
    rx_push(8'h11); rx_push(8'h22);
    rd_chk("R9 rx level", 8'hD8, 2);
    rd_chk("R11 peek", 8'hEC, 32'h11);
    rd_chk("R11 peek keeps", 8'hD8, 2);
    rd_chk("R11 pop0", 8'hE8, 32'h11);
    rd_chk("R11 pop1", 8'hE8, 32'h22);
    rd_chk("R12 pop empty", 8'hE8, 0);
    rd_chk("R12 peek empty", 8'hEC, 0);
    rd_chk("R12 level zero", 8'hD8, 0);

    for (int i = 0; i < 12; i++) rx_push(8'h40 + 8'(i));
    idle(1);
    rd(8'h84, d);
    chk("R4 rx high mark", {31'd0, d[2]}, 1);
    for (int i = 12; i < 17; i++) rx_push(8'h40 + 8'(i));
    chk("R12 rx full", {31'd0, rx_full_o}, 1);
    rd_chk("R12 rx level capped", 8'hD8, 16);
    for (int i = 0; i < 16; i++) rd_chk("R11 rx drain", 8'hE8, 32'h40 + i);

    // random mix against queue models
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: begin
          logic [15:0] v = 16'($urandom);
          wr(8'hE0, {16'd0, v});
          if (cq.size() < 16) cq.push_back(v);
        end
        1: begin
          if (cq.size() > 0) begin
            chk("R10 rand cmd head", {16'd0, cmd_data_o}, {16'd0, cq.pop_front()});
          end
          cmd_pop();
        end
        2: begin
          logic [7:0] v = 8'($urandom);
          rx_push(v);
          if (rq.size() < 16) rq.push_back(v);
        end
        default: begin
          logic [31:0] e = (rq.size() > 0) ? {24'd0, rq.pop_front()} : 32'd0;
          rd_chk("R11 rand rx pop", 8'hE8, e);
        end
      endcase
    end
    rd_chk("R9 rand cmd room", 8'hD0, 32'(16 - cq.size()));
    rd_chk("R9 rand rx level", 8'hD8, 32'(rq.size()));
    wr(8'h84, 32'hFF);
    rd_chk("R4 rand watermarks", 8'h84, exp_wm(cq.size(), 0, rq.size()));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule